// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is an 8-bit timer that ramps its count from zero up to the all-ones value and back down again, over and over. One compare channel watches the ramp and drives a pulse-width modulated pin. Because the edges of each pulse sit symmetrically around the bottom of the ramp, the pulse centre does not move when the duty cycle changes. A free-running clock divider sets how often the ramp takes a step. A two-bit output-mode field either keeps the pin off or selects a true or a complemented waveform.

Software writes two registers over a single-cycle write port. The compare value is first written into a holding register. It only moves into the live comparator when the ramp reaches its peak, so a rewrite in mid-period can never cut a pulse short. A sticky flag marks each return to the bottom of the ramp. A separate clear input acknowledges it, and when a clear and a new bottom event fall in the same cycle, the event wins.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: After synchronous reset the count is 0 and the ramp direction is up. The pin, its drive enable and the flag are all low, and both compare registers hold 0.
- R2: Each timer step moves the count by one. It rises from 0 to 255, then falls from 255 to 0, then repeats, so a full period is 510 steps.
- R3: Control register (address 0), bits [2:0], selects the step rate. Code 0 halts the count. Codes 1 to 7 give one step every 1, 8, 32, 64, 128, 256 or 1024 clock cycles.
- R4: Output mode 2 (control bits [5:4] = 2'b10) gives the true waveform. The pin falls when the rising count meets the compare value and rises when the falling count meets it, so the pin is high for 2*K of the 510 steps for a compare value K.
- R5: Output mode 3 (2'b11) gives the complement: the pin rises on the upward match and falls on the downward match, so it is high for 510-2*K steps.
- R6: A live compare value of 0 holds the true waveform low for the whole period. A value of 255 holds it high. In mode 3 these levels are swapped.
- R7: Output modes 0 and 1 keep the pin low and the drive enable low. Modes 2 and 3 set the drive enable.
- R8: A write to address 1 loads only the holding register. The live compare value takes the held value on the step that brings the count to 255, and never at any other time.
- R9: The flag goes high on every step that brings the count to 0 and stays high until it is cleared.
- R10: A high on the clear input lowers the flag on the next edge, unless a step to 0 happens in that same cycle, in which case the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects the control register, 1 the compare holding register |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clears the bottom flag |
| cnt_o | output | 8 | Current count value |
| pwm_o | output | 1 | Waveform pin |
| pwm_oe | output | 1 | High while the waveform drives the pin |
| ovf_o | output | 1 | Sticky bottom-of-ramp flag |

## Verification
The flag's set event and its clear request can land on the same edge. The bench provokes this by holding the clear input high for a whole falling half-ramp. It then judges that the flag reads high in the sample where the count shows 0, and reads low one step later. A second collision is the compare reload coinciding with the peak match. The bench rewrites the compare value mid-ramp and checks the pin level on both sides of the next peak, then measures full-period high times for boundary and interior compare values in both polarities.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W = 8;
    localparam int DIV_W = 10;
    localparam int SEL_W = 3;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMP  = 1;

    typedef enum logic [1:0] {
        OM_OFF     = 2'd0,
        OM_OFF_ALT = 2'd1,
        OM_NONINV  = 2'd2,
        OM_INV     = 2'd3
    } outmode_e;

    typedef struct packed {
        outmode_e             mode;
        logic [SEL_W-1:0]     clk_sel;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             rising;
    } cnt_state_t;

    // log2 of the division ratio for each rate code
    function automatic int unsigned presc_shift(logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic drives_pin(outmode_e m);
        return (m == OM_NONINV) || (m == OM_INV);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int DIV_BITS = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int NSEL = 2 ** SEL_W;

    logic [DIV_BITS-1:0] div_q;
    logic [DIV_BITS-1:0] mask_tab [NSEL];

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_mask
        localparam int unsigned SH_RAW = presc_shift(SEL_W'(g));
        localparam int unsigned SH     = (SH_RAW > DIV_BITS) ? DIV_BITS : SH_RAW;
        assign mask_tab[g] = DIV_BITS'((64'd1 << SH) - 64'd1);
    end

    assign tick = (sel != '0) && ((div_q & mask_tab[sel]) == mask_tab[sel]);

    // R3: a halted rate code never produces a step
    a_r3_halt_no_tick: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> !tick);

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
    import pwm_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cmp_we,
    input  logic [WIDTH-1:0] cmp_wdata,
    output logic [WIDTH-1:0] cnt,
    output logic             rising,
    output logic [WIDTH-1:0] cnt_nxt,
    output logic [WIDTH-1:0] cmp_eff,
    output logic             hit_bottom
);

    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] BOT = '0;

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             rising;
    } st_t;

    st_t              st_q, st_d;
    logic [WIDTH-1:0] cmp_buf_q;
    logic [WIDTH-1:0] cmp_act_q;
    logic             reach_top;

    always_comb begin
        st_d = st_q;
        if (st_q.rising) begin
            st_d.value  = st_q.value + 1'b1;
            st_d.rising = (st_d.value != TOP);
        end else begin
            st_d.value  = st_q.value - 1'b1;
            st_d.rising = (st_d.value == BOT);
        end
    end

    assign cnt_nxt    = st_d.value;
    assign reach_top  = tick && (st_d.value == TOP);
    assign hit_bottom = tick && (st_d.value == BOT);
    assign cmp_eff    = reach_top ? cmp_buf_q : cmp_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.value  <= BOT;
            st_q.rising <= 1'b1;
        end else if (tick) begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_buf_q <= '0;
        else if (cmp_we) cmp_buf_q <= cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)            cmp_act_q <= '0;
        else if (reach_top) cmp_act_q <= cmp_buf_q;
    end

    assign cnt    = st_q.value;
    assign rising = st_q.rising;

    // R2: one step moves the count by exactly one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((cnt == WIDTH'($past(cnt) + 1'b1)) || (cnt == WIDTH'($past(cnt) - 1'b1))));
    // R2: without a step the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    // R2: turnaround points carry the right direction
    a_r2_peak_falls: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |-> !rising);
    a_r2_floor_rises: assert property (@(posedge clk) disable iff (rst)
        (cnt == BOT) |-> rising);
    // R8: live compare value changes only at the peak
    a_r8_load_at_peak: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_act_q) |-> (cnt == TOP));

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             step_up,
    input  logic [WIDTH-1:0] cnt_nxt,
    input  logic [WIDTH-1:0] cmp_eff,
    input  outmode_e         mode,
    output logic             pwm,
    output logic             oe
);

    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] BOT = '0;

    logic lvl_q, lvl_d;

    always_comb begin
        lvl_d = lvl_q;
        if (tick) begin
            if (cmp_eff == BOT)          lvl_d = 1'b0;
            else if (cmp_eff == TOP)     lvl_d = 1'b1;
            else if (cnt_nxt == cmp_eff) lvl_d = !step_up;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_d;
    end

    assign oe  = drives_pin(mode);
    assign pwm = oe && (lvl_q ^ (mode == OM_INV));

    // R6: compare at bottom pins the true level low
    a_r6_floor_low: assert property (@(posedge clk) disable iff (rst)
        (tick && (cmp_eff == BOT)) |=> !lvl_q);
    // R6: compare at peak pins the true level high
    a_r6_peak_high: assert property (@(posedge clk) disable iff (rst)
        (tick && (cmp_eff == TOP)) |=> lvl_q);
    // R7: off modes keep the pin quiet
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |-> (!pwm && !oe));

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
    import pwm_pkg::*;
#(
    parameter int WIDTH    = CNT_W,
    parameter int DIV_BITS = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] cnt_o,
    output logic             pwm_o,
    output logic             pwm_oe,
    output logic             ovf_o
);

    ctrl_t            ctrl_q;
    logic             tick;
    logic             rising;
    logic [WIDTH-1:0] cnt_nxt;
    logic [WIDTH-1:0] cmp_eff;
    logic             hit_bottom;
    logic             ovf_q;
    logic             cmp_we;
    logic             ctrl_we;
    logic             unused_wr_bits;

    assign ctrl_we        = wr_en && (wr_addr == 1'(ADDR_CTRL));
    assign cmp_we         = wr_en && (wr_addr == 1'(ADDR_CMP));
    assign unused_wr_bits = ^{wr_data[WIDTH-1:6], wr_data[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode    <= OM_OFF;
            ctrl_q.clk_sel <= '0;
        end else if (ctrl_we) begin
            ctrl_q.mode    <= outmode_e'(wr_data[5:4]);
            ctrl_q.clk_sel <= wr_data[SEL_W-1:0];
        end
    end

    pwm_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.clk_sel),
        .tick (tick)
    );

    pwm_updown_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cmp_we     (cmp_we),
        .cmp_wdata  (wr_data),
        .cnt        (cnt_o),
        .rising     (rising),
        .cnt_nxt    (cnt_nxt),
        .cmp_eff    (cmp_eff),
        .hit_bottom (hit_bottom)
    );

    pwm_wave_gen #(.WIDTH(WIDTH)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .step_up (rising),
        .cnt_nxt (cnt_nxt),
        .cmp_eff (cmp_eff),
        .mode    (ctrl_q.mode),
        .pwm     (pwm_o),
        .oe      (pwm_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)             ovf_q <= 1'b0;
        else if (hit_bottom) ovf_q <= 1'b1;
        else if (ovf_clr)    ovf_q <= 1'b0;
    end

    assign ovf_o = ovf_q;

    // R9: every arrival at the bottom raises the flag
    a_r9_set_on_bottom: assert property (@(posedge clk) disable iff (rst)
        hit_bottom |=> ovf_o);
    // R9: the flag only rises through a bottom arrival
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> (cnt_o == '0));
    // R10: a clear without a competing set lowers the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !hit_bottom) |=> !ovf_o);

endmodule

// File: tb/sim_pwm_dual_slope_timer.sv
module sim_pwm_dual_slope_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       ovf_clr = 1'b0;
    logic [7:0] cnt_o;
    logic       pwm_o;
    logic       pwm_oe;
    logic       ovf_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwm_dual_slope_timer u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ovf_clr (ovf_clr),
        .cnt_o   (cnt_o),
        .pwm_o   (pwm_o),
        .pwm_oe  (pwm_oe),
        .ovf_o   (ovf_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_ctrl(input logic [1:0] mode, input logic [2:0] sel);
        wr(1'b0, {2'b00, mode, 1'b0, sel});
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        do @(negedge clk); while (cnt_o != v);
    endtask

    task automatic duty(input int k, input logic [1:0] mode);
        int highs;
        int expv;
        int oe_bad;
        highs  = 0;
        oe_bad = 0;
        set_ctrl(mode, 3'd1);
        wr(1'b1, 8'(k));
        wait_cnt(8'd0); wait_cnt(8'd255);
        wait_cnt(8'd0); wait_cnt(8'd255);
        for (int i = 0; i < 510; i++) begin
            highs += int'(pwm_o);
            if (pwm_oe != mode[1]) oe_bad++;
            @(negedge clk);
        end
        if (!mode[1])          expv = 0;
        else if (mode == 2'd2) expv = 2 * k;
        else                   expv = 510 - 2 * k;
        if (mode == 2'd2)      chk(highs == expv, $sformatf("R4/R6 true high steps K=%0d", k), highs, expv);
        else if (mode == 2'd3) chk(highs == expv, $sformatf("R5/R6 complement high steps K=%0d", k), highs, expv);
        else                   chk(highs == expv, $sformatf("R7 off-mode high steps mode=%0d", mode), highs, expv);
        chk(oe_bad == 0, $sformatf("R7 drive enable mode=%0d", mode), oe_bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int errs;
        int n;
        logic [7:0] prev;
        int ratio [8];
        ratio = '{0, 1, 8, 32, 64, 128, 256, 1024};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cnt_o == 8'd0, "R1 count after reset", cnt_o, 0);
        chk(pwm_o == 1'b0, "R1 pin after reset", pwm_o, 0);
        chk(pwm_oe == 1'b0, "R1 enable after reset", pwm_oe, 0);
        chk(ovf_o == 1'b0, "R1 flag after reset", ovf_o, 0);
        repeat (20) @(negedge clk);
        chk(cnt_o == 8'd0, "R3 rate code 0 at reset holds count", cnt_o, 0);

        // R2 triangle shape
        set_ctrl(2'd2, 3'd1);
        wait_cnt(8'd255);
        wait_cnt(8'd0);
        errs = 0;
        for (int k = 0; k < 510; k++) begin
            if (int'(cnt_o) != ((k <= 255) ? k : 510 - k)) errs++;
            @(negedge clk);
        end
        chk(errs == 0, "R2 count sequence over 510 steps", errs, 0);
        chk(cnt_o == 8'd0, "R2 period returns to 0 after 510", cnt_o, 0);

        // R4 R5 R6 R7 duty sweeps
        foreach (ratio[i]) ;
        duty(0, 2'd2);   duty(1, 2'd2);   duty(2, 2'd2);   duty(77, 2'd2);
        duty(128, 2'd2); duty(253, 2'd2); duty(254, 2'd2); duty(255, 2'd2);
        duty(0, 2'd3);   duty(1, 2'd3);   duty(77, 2'd3);  duty(128, 2'd3);
        duty(254, 2'd3); duty(255, 2'd3);
        duty(100, 2'd0); duty(100, 2'd1);

        // R8 buffered compare
        set_ctrl(2'd2, 3'd1);
        wr(1'b1, 8'd200);
        wait_cnt(8'd0); wait_cnt(8'd255); wait_cnt(8'd0);
        wait_cnt(8'd10);
        chk(pwm_o == 1'b1, "R4 high below compare while rising", pwm_o, 1);
        wr(1'b1, 8'd100);
        wait_cnt(8'd150);
        chk(pwm_o == 1'b1, "R8 new value not live before peak", pwm_o, 1);
        wait_cnt(8'd255);
        wait_cnt(8'd150);
        chk(pwm_o == 1'b0, "R8 low above new value while falling", pwm_o, 0);
        wait_cnt(8'd99);
        chk(pwm_o == 1'b1, "R8 new value live after peak", pwm_o, 1);

        // R9 R10 flag
        ovf_clr = 1'b1;
        wait_cnt(8'd255);
        wait_cnt(8'd128);
        chk(ovf_o == 1'b0, "R10 clear lowers flag", ovf_o, 0);
        wait_cnt(8'd0);
        chk(ovf_o == 1'b1, "R10 set wins over clear", ovf_o, 1);
        @(negedge clk);
        chk(ovf_o == 1'b0, "R10 clear takes effect next step", ovf_o, 0);
        ovf_clr = 1'b0;
        wait_cnt(8'd255);
        chk(ovf_o == 1'b0, "R9 flag low before bottom", ovf_o, 0);
        wait_cnt(8'd0);
        chk(ovf_o == 1'b1, "R9 flag set at bottom", ovf_o, 1);
        wait_cnt(8'd40);
        chk(ovf_o == 1'b1, "R9 flag sticky", ovf_o, 1);

        // R3 rate codes
        for (int s = 1; s < 8; s++) begin
            set_ctrl(2'd2, 3'(s));
            prev = cnt_o;
            do @(negedge clk); while (cnt_o == prev);
            prev = cnt_o;
            n = 0;
            do begin @(negedge clk); n++; end while (cnt_o == prev);
            chk(n == ratio[s], $sformatf("R3 cycles per step code %0d", s), n, ratio[s]);
        end
        set_ctrl(2'd2, 3'd0);
        repeat (2) @(negedge clk);
        prev = cnt_o;
        errs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cnt_o != prev) errs++;
        end
        chk(errs == 0, "R3 code 0 halts count", errs, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule